// File: doc/BRIEF.md
# Subchannel Byte Transfer Engine

This block is the byte data path of one I/O subchannel. A control agent loads a transfer descriptor, which gives a starting byte address, a byte count, a direction, a skip flag and a protection key. The engine then moves bytes between a device-side byte stream and a word-wide memory port. The byte address moves by one and the count drops by one for every byte handled. When the count is used up, the engine signals completion and waits for the next descriptor.

Stores into memory are guarded by a per-page lock table, which sits behind a one-cycle lookup port. The engine keeps the lock of the page it is writing and fetches a new one whenever the address enters another page. With the skip flag set, the transfer runs its full length without touching memory. Inbound bytes are consumed and dropped, and outbound bytes are zeros. A protection failure ends the transfer at once with an unusual-end pulse.

Top module: `chan_xfer_engine`

## Requirements
- R1: After reset, busy, cnt_zero, unusual_end, dev_in_ready, dev_out_valid, mem_rd_req, mem_wr_req and lock_req are all 0.
- R2: With dsc_dir code 0 (input) and skip clear, each byte accepted from the device at byte address a is written with mem_addr = a>>2, mem_be bit (a mod 4) alone set, and the byte in mem_wdata bits 8k+7:8k where k = a mod 4. After the byte the address is a+1 and the count is one less.
- R3: With dsc_dir code 1 (input, backward), the byte address goes down by one per byte. Codes 0, 2 and 3 raise it.
- R4: With skip set on input, device bytes are accepted and dropped, and no memory write is made. Address and count still step once per byte.
- R5: With dsc_dir code 2 or 3 (output) and skip clear, a memory read is made only when the output buffer is empty. The read supplies the bytes from the current address up to the end of its 4-byte word, but no more than the remaining count. The bytes reach the device in rising address order.
- R6: On output with skip set, no memory read is made and the device receives only zero bytes, one per counted byte.
- R7: A store is allowed when the key is 0, or the lock of the target page is 0, or the key equals that lock.
- R8: A page is 512 bytes (page = address>>9). Before the first store of a descriptor, and again before the first store in any new page, the engine issues lock_req with lock_page and takes lock_val one cycle later.
- R9: A byte that breaks the lock rule is not stored. unusual_end pulses for one cycle, busy drops, and the address and count keep the values they had at that byte.
- R10: cnt_zero pulses for exactly one cycle, in the cycle busy drops, once the count is zero and every output byte has been taken by the device. A descriptor with count 0 completes at once in this way.
- R11: dsc_load is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsc_load | input | 1 | Load descriptor (taken only when idle) |
| dsc_addr | input | ADDR_W | Starting byte address |
| dsc_count | input | CNT_W | Byte count |
| dsc_dir | input | 2 | 0 input, 1 input backward, 2/3 output |
| dsc_skip | input | 1 | Skip memory access |
| dsc_key | input | KEY_W | Protection key |
| busy | output | 1 | Transfer in progress |
| xfer_addr | output | ADDR_W | Current byte address |
| xfer_count | output | CNT_W | Remaining byte count |
| cnt_zero | output | 1 | One-cycle completion pulse |
| unusual_end | output | 1 | One-cycle protection-failure pulse |
| dev_in_valid | input | 1 | Device offers an inbound byte |
| dev_in_data | input | 8 | Inbound byte |
| dev_in_ready | output | 1 | Engine accepts an inbound byte |
| dev_out_valid | output | 1 | Outbound byte available |
| dev_out_data | output | 8 | Outbound byte |
| dev_out_ready | input | 1 | Device takes the outbound byte |
| mem_rd_req | output | 1 | Word read request, data next cycle |
| mem_wr_req | output | 1 | Byte-enabled word write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data (byte replicated) |
| mem_rdata | input | 32 | Read data |
| lock_req | output | 1 | Lock table lookup |
| lock_page | output | ADDR_W-9 | Page being looked up |
| lock_val | input | KEY_W | Lock value, one cycle after lock_req |

## Verification
The assertions assume that the memory and lock ports answer exactly one cycle after a request. They also assume that the device holds dev_in_data steady while dev_in_valid is high and the byte has not yet been taken. The bench models both ports as registered lookups from computed tables, so that assumption holds by design. Its device driver changes the byte only after a sampled handshake. The stimulus includes a store sequence that crosses from an open page into a locked one, and dev_out_ready is held low while a second load arrives. These runs exercise the refetch, abort and ignore rules under realistic timing.

// File: rtl/chan_xfer_pkg.sv
package chan_xfer_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOCK,
      ST_LWAIT,
      ST_RUN,
      ST_FILL
   } xfer_state_e;
endpackage

// File: rtl/chan_lock_check.sv
module chan_lock_check #(
   parameter int KEY_W  = 4,
   parameter int PAGE_W = 7
) (
   input  logic [KEY_W-1:0]  key,
   input  logic [KEY_W-1:0]  lock,
   input  logic [PAGE_W-1:0] page_now,
   input  logic [PAGE_W-1:0] page_held,
   input  logic              held_ok,
   output logic              allow,
   output logic              refetch
);
   assign allow   = (key == '0) || (lock == '0) || (key == lock);
   assign refetch = !held_ok || (page_now != page_held);
endmodule

// File: rtl/chan_out_buf.sv
module chan_out_buf #(
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill,
   input  logic [8*WORD_BYTES-1:0] fill_word,
   input  logic [$clog2(WORD_BYTES)-1:0] fill_lane,
   input  logic [$clog2(WORD_BYTES):0]   fill_n,
   input  logic                    pop,
   output logic                    empty,
   output logic [7:0]              data
);
   localparam int LANE_W = $clog2(WORD_BYTES);

   logic [8*WORD_BYTES-1:0] word_q;
   logic [LANE_W-1:0]       ptr_q;
   logic [LANE_W:0]         left_q;
   logic [7:0]              lane_b [WORD_BYTES];

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign lane_b[g] = word_q[8*g +: 8];
   end

   assign empty = (left_q == '0);
   assign data  = lane_b[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         ptr_q  <= '0;
         left_q <= '0;
      end else if (fill) begin
         word_q <= fill_word;
         ptr_q  <= fill_lane;
         left_q <= fill_n;
      end else if (pop && !empty) begin
         ptr_q  <= ptr_q + LANE_W'(1);
         left_q <= left_q - (LANE_W+1)'(1);
      end
   end
endmodule

// File: rtl/chan_xfer_engine.sv
module chan_xfer_engine
   import chan_xfer_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int KEY_W      = 4,
   parameter int PAGE_BITS  = 9,
   parameter int WORD_BYTES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dsc_load,
   input  logic [ADDR_W-1:0]             dsc_addr,
   input  logic [CNT_W-1:0]              dsc_count,
   input  logic [1:0]                    dsc_dir,
   input  logic                          dsc_skip,
   input  logic [KEY_W-1:0]              dsc_key,
   output logic                          busy,
   output logic [ADDR_W-1:0]             xfer_addr,
   output logic [CNT_W-1:0]              xfer_count,
   output logic                          cnt_zero,
   output logic                          unusual_end,
   input  logic                          dev_in_valid,
   input  logic [7:0]                    dev_in_data,
   output logic                          dev_in_ready,
   output logic                          dev_out_valid,
   output logic [7:0]                    dev_out_data,
   input  logic                          dev_out_ready,
   output logic                          mem_rd_req,
   output logic                          mem_wr_req,
   output logic [ADDR_W-$clog2(WORD_BYTES)-1:0] mem_addr,
   output logic [WORD_BYTES-1:0]         mem_be,
   output logic [8*WORD_BYTES-1:0]       mem_wdata,
   input  logic [8*WORD_BYTES-1:0]       mem_rdata,
   output logic                          lock_req,
   output logic [ADDR_W-PAGE_BITS-1:0]   lock_page,
   input  logic [KEY_W-1:0]              lock_val
);
   localparam int LANE_W = $clog2(WORD_BYTES);
   localparam int PAGE_W = ADDR_W - PAGE_BITS;

   if ((1 << LANE_W) != WORD_BYTES || WORD_BYTES < 2) begin : g_bad_word
      $error("WORD_BYTES must be a power of two, at least 2");
   end
   if (PAGE_BITS <= LANE_W || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must lie between the lane bits and ADDR_W");
   end
   if (CNT_W <= LANE_W) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   xfer_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              mode_out, mode_back, skip_q;
   logic [KEY_W-1:0]  key_q, lock_q;
   logic [PAGE_W-1:0] page_q;
   logic              page_ok_q;
   logic              cz_q, ue_q;

   logic              allow, refetch;
   logic              store_mode, in_hs, violation, buf_empty, fill_en, done;
   logic [LANE_W-1:0] lane;
   logic [LANE_W:0]   room, fill_n;

   chan_lock_check #(.KEY_W(KEY_W), .PAGE_W(PAGE_W)) i_lock (
      .key       (key_q),
      .lock      (lock_q),
      .page_now  (addr_q[ADDR_W-1:PAGE_BITS]),
      .page_held (page_q),
      .held_ok   (page_ok_q),
      .allow     (allow),
      .refetch   (refetch)
   );

   assign lane       = addr_q[LANE_W-1:0];
   assign room       = (LANE_W+1)'(WORD_BYTES) - {1'b0, lane};
   assign fill_n     = (cnt_q < CNT_W'(room)) ? cnt_q[LANE_W:0] : room;
   assign store_mode = !mode_out && !skip_q;
   assign in_hs      = dev_in_valid && dev_in_ready;
   assign violation  = in_hs && store_mode && !allow;

   assign dev_in_ready = (state_q == ST_RUN) && !mode_out && (cnt_q != '0)
                         && !(store_mode && refetch);
   assign mem_wr_req   = in_hs && store_mode && allow;
   assign mem_rd_req   = (state_q == ST_RUN) && mode_out && !skip_q
                         && buf_empty && (cnt_q != '0);
   assign fill_en      = (state_q == ST_FILL) ||
                         ((state_q == ST_RUN) && mode_out && skip_q
                          && buf_empty && (cnt_q != '0));
   assign done         = (state_q == ST_RUN) && (cnt_q == '0)
                         && (!mode_out || buf_empty);

   assign mem_addr  = addr_q[ADDR_W-1:LANE_W];
   assign mem_wdata = {WORD_BYTES{dev_in_data}};
   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_be
      assign mem_be[g] = mem_wr_req && (lane == LANE_W'(g));
   end

   assign lock_req  = (state_q == ST_LOCK);
   assign lock_page = addr_q[ADDR_W-1:PAGE_BITS];

   chan_out_buf #(.WORD_BYTES(WORD_BYTES)) i_obuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (fill_en),
      .fill_word (skip_q ? '0 : mem_rdata),
      .fill_lane (lane),
      .fill_n    (fill_n),
      .pop       (dev_out_ready),
      .empty     (buf_empty),
      .data      (dev_out_data)
   );
   assign dev_out_valid = !buf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         cnt_q     <= '0;
         mode_out  <= 1'b0;
         mode_back <= 1'b0;
         skip_q    <= 1'b0;
         key_q     <= '0;
         lock_q    <= '0;
         page_q    <= '0;
         page_ok_q <= 1'b0;
         cz_q      <= 1'b0;
         ue_q      <= 1'b0;
      end else begin
         cz_q <= 1'b0;
         ue_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (dsc_load) begin
               addr_q    <= dsc_addr;
               cnt_q     <= dsc_count;
               mode_out  <= dsc_dir[1];
               mode_back <= (dsc_dir == 2'd1);
               skip_q    <= dsc_skip;
               key_q     <= dsc_key;
               page_ok_q <= 1'b0;
               state_q   <= ST_RUN;
            end
            ST_LOCK:  state_q <= ST_LWAIT;
            ST_LWAIT: begin
               lock_q    <= lock_val;
               page_q    <= addr_q[ADDR_W-1:PAGE_BITS];
               page_ok_q <= 1'b1;
               state_q   <= ST_RUN;
            end
            ST_RUN: begin
               if (done) begin
                  cz_q    <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (mode_out) begin
                  if (mem_rd_req) begin
                     state_q <= ST_FILL;
                  end else if (fill_en) begin
                     addr_q <= addr_q + ADDR_W'(fill_n);
                     cnt_q  <= cnt_q - CNT_W'(fill_n);
                  end
               end else if (store_mode && refetch) begin
                  state_q <= ST_LOCK;
               end else if (violation) begin
                  ue_q    <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (in_hs) begin
                  addr_q <= mode_back ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
                  cnt_q  <= cnt_q - CNT_W'(1);
               end
            end
            ST_FILL: begin
               addr_q  <= addr_q + ADDR_W'(fill_n);
               cnt_q   <= cnt_q - CNT_W'(fill_n);
               state_q <= ST_RUN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign xfer_addr   = addr_q;
   assign xfer_count  = cnt_q;
   assign cnt_zero    = cz_q;
   assign unusual_end = ue_q;
endmodule

// File: rtl/chan_xfer_chk.sv
module chan_xfer_chk #(
   parameter int CNT_W = 16,
   parameter int KEY_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             skip_q,
   input logic             mode_out,
   input logic [KEY_W-1:0] key_q,
   input logic [KEY_W-1:0] lock_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             mem_wr_req,
   input logic             mem_rd_req,
   input logic             dev_in_valid,
   input logic             dev_in_ready,
   input logic             dev_out_valid,
   input logic             cnt_zero,
   input logic             unusual_end
);
   // R4
   skip_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> (!mem_wr_req && !mem_rd_req));

   // R7
   lock_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> (key_q == '0 || lock_q == '0 || key_q == lock_q));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_in_valid && dev_in_ready && (skip_q || mem_wr_req))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R5
   read_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mode_out && !dev_out_valid));

   // R10
   cz_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_zero |=> !cnt_zero);

   // R9
   ue_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unusual_end |-> (!busy && !cnt_zero));
endmodule

bind chan_xfer_engine chan_xfer_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .skip_q        (skip_q),
   .mode_out      (mode_out),
   .key_q         (key_q),
   .lock_q        (lock_q),
   .cnt_q         (cnt_q),
   .mem_wr_req    (mem_wr_req),
   .mem_rd_req    (mem_rd_req),
   .dev_in_valid  (dev_in_valid),
   .dev_in_ready  (dev_in_ready),
   .dev_out_valid (dev_out_valid),
   .cnt_zero      (cnt_zero),
   .unusual_end   (unusual_end)
);

// File: tb/test_chan_xfer_engine.sv
`timescale 1ns/1ps
module test_chan_xfer_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dsc_load = 1'b0;
   logic [15:0] dsc_addr = '0;
   logic [15:0] dsc_count = '0;
   logic [1:0]  dsc_dir = '0;
   logic        dsc_skip = 1'b0;
   logic [3:0]  dsc_key = '0;
   logic        busy, cnt_zero, unusual_end;
   logic [15:0] xfer_addr, xfer_count;
   logic        dev_in_valid = 1'b0;
   logic [7:0]  dev_in_data = '0;
   logic        dev_in_ready, dev_out_valid;
   logic [7:0]  dev_out_data;
   logic        dev_out_ready = 1'b1;
   logic        mem_rd_req, mem_wr_req;
   logic [13:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        lock_req;
   logic [6:0]  lock_page;
   logic [3:0]  lock_val = '0;

   always #10 clk = ~clk;

   chan_xfer_engine i_chan_xfer_engine (
      .clk(clk), .rst_n(rst_n), .dsc_load(dsc_load), .dsc_addr(dsc_addr),
      .dsc_count(dsc_count), .dsc_dir(dsc_dir), .dsc_skip(dsc_skip),
      .dsc_key(dsc_key), .busy(busy), .xfer_addr(xfer_addr),
      .xfer_count(xfer_count), .cnt_zero(cnt_zero), .unusual_end(unusual_end),
      .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
      .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
      .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .lock_req(lock_req), .lock_page(lock_page), .lock_val(lock_val)
   );

   int nchk = 0;
   int nfail = 0;
   int cz_seen = 0;
   int ue_seen = 0;
   int cycles = 0;
   bit out_skip_run = 1'b0;

   typedef struct {
      logic [13:0] wa;
      logic [1:0]  lane;
      logic [7:0]  d;
   } wr_t;
   wr_t         wr_q[$];
   logic [7:0]  out_q[$];

   function automatic logic [7:0] byte_at(input logic [15:0] a);
      return a[7:0] + 8'h31;
   endfunction

   function automatic logic [3:0] lock_of(input logic [6:0] p);
      if (p == 7'd2) return 4'd7;
      if (p == 7'd3) return 4'd0;
      return 4'd3;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory and lock table: one-cycle registered lookups
   always @(posedge clk) begin
      if (mem_rd_req)
         for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] <= byte_at({mem_addr, 2'(k)});
      if (lock_req) lock_val <= lock_of(lock_page);
   end

   // monitor: samples 5 ns after the falling edge
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (mem_wr_req) begin
            if (wr_q.size() == 0) begin
               check(1'b0, "R2/R4/R9 unexpected store", {18'd0, mem_addr}, 0);
            end else begin
               wr_t e;
               e = wr_q.pop_front();
               check(mem_addr == e.wa, "R2 store word address", {18'd0, mem_addr}, {18'd0, e.wa});
               check(mem_be == (4'b1 << e.lane), "R2 store byte enable", {28'd0, mem_be},
                     {28'd0, 4'b1 << e.lane});
               check(mem_wdata[8*e.lane +: 8] == e.d, "R2 store data",
                     {24'd0, mem_wdata[8*e.lane +: 8]}, {24'd0, e.d});
            end
         end
         if (dev_out_valid && dev_out_ready) begin
            if (out_q.size() == 0) begin
               check(1'b0, "R5/R6 unexpected output byte", {24'd0, dev_out_data}, 0);
            end else begin
               logic [7:0] x;
               x = out_q.pop_front();
               check(dev_out_data == x, "R5/R6 output byte", {24'd0, dev_out_data}, {24'd0, x});
            end
         end
         if (mem_rd_req && out_skip_run) check(1'b0, "R6 read during skip", 1, 0);
         if (cnt_zero) cz_seen++;
         if (unusual_end) ue_seen++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   task automatic load(input logic [15:0] a, input logic [15:0] c, input logic [1:0] d,
                       input logic s, input logic [3:0] k);
      dsc_addr = a; dsc_count = c; dsc_dir = d; dsc_skip = s; dsc_key = k;
      dsc_load = 1'b1;
      @(negedge clk);
      dsc_load = 1'b0;
   endtask

   task automatic send_in(input logic [7:0] d);
      bit r;
      dev_in_valid = 1'b1;
      dev_in_data  = d;
      forever begin
         r = dev_in_ready;
         @(posedge clk);
         @(negedge clk);
         if (r) break;
      end
   endtask

   task automatic expect_store(input logic [15:0] a);
      wr_t e;
      e.wa = a[15:2]; e.lane = a[1:0]; e.d = byte_at(a);
      wr_q.push_back(e);
   endtask

   task automatic wait_idle();
      dev_in_valid = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int cz0, ue0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !cnt_zero && !unusual_end, "R1 status after reset",
            {busy, cnt_zero, unusual_end}, 0);
      check(!dev_in_ready && !dev_out_valid && !mem_rd_req && !mem_wr_req && !lock_req,
            "R1 handshakes after reset",
            {dev_in_ready, dev_out_valid, mem_rd_req, mem_wr_req, lock_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R8: forward input across page 0 -> page 1 (both lock 3)
      cz0 = cz_seen;
      for (int i = 0; i < 4; i++) expect_store(16'h01FE + 16'(i));
      load(16'h01FE, 16'd4, 2'd0, 1'b0, 4'd3);
      for (int i = 0; i < 4; i++) send_in(byte_at(16'h01FE + 16'(i)));
      wait_idle();
      check(wr_q.size() == 0, "R2 R8 all forward stores seen", wr_q.size(), 0);
      check(xfer_addr == 16'h0202, "R2 final address", xfer_addr, 16'h0202);
      check(cz_seen - cz0 == 1, "R10 one count-zero pulse", cz_seen - cz0, 1);

      // R3: backward input 0x201 down to 0x1FE
      for (int i = 0; i < 4; i++) expect_store(16'h0201 - 16'(i));
      load(16'h0201, 16'd4, 2'd1, 1'b0, 4'd3);
      for (int i = 0; i < 4; i++) send_in(byte_at(16'h0201 - 16'(i)));
      wait_idle();
      check(wr_q.size() == 0, "R3 all backward stores seen", wr_q.size(), 0);
      check(xfer_addr == 16'h01FD, "R3 backward final address", xfer_addr, 16'h01FD);

      // R9 R8: page 1 open for key 3, page 2 locked with 7
      cz0 = cz_seen; ue0 = ue_seen;
      expect_store(16'h03FE); expect_store(16'h03FF);
      load(16'h03FE, 16'd4, 2'd0, 1'b0, 4'd3);
      for (int i = 0; i < 3; i++) send_in(byte_at(16'h03FE + 16'(i)));
      wait_idle();
      check(wr_q.size() == 0, "R9 stores before violation", wr_q.size(), 0);
      check(ue_seen - ue0 == 1, "R9 unusual end pulse", ue_seen - ue0, 1);
      check(cz_seen == cz0, "R9 no count-zero on abort", cz_seen - cz0, 0);
      check(xfer_addr == 16'h0400 && xfer_count == 16'd2, "R9 address and count held",
            {xfer_addr, xfer_count}, {16'h0400, 16'd2});

      // R7: key 0 into locked page 2; key 5 into open page 3
      expect_store(16'h0400); expect_store(16'h0401);
      load(16'h0400, 16'd2, 2'd0, 1'b0, 4'd0);
      send_in(byte_at(16'h0400)); send_in(byte_at(16'h0401));
      wait_idle();
      expect_store(16'h0600);
      load(16'h0600, 16'd1, 2'd0, 1'b0, 4'd5);
      send_in(byte_at(16'h0600));
      wait_idle();
      check(wr_q.size() == 0, "R7 zero key or zero lock allows", wr_q.size(), 0);

      // R4: skipped input with a mismatched key
      cz0 = cz_seen; ue0 = ue_seen;
      load(16'h0410, 16'd3, 2'd0, 1'b1, 4'd9);
      for (int i = 0; i < 3; i++) send_in(8'hA0 + 8'(i));
      wait_idle();
      check(xfer_addr == 16'h0413 && xfer_count == 16'd0, "R4 skip advances address",
            {xfer_addr, xfer_count}, {16'h0413, 16'd0});
      check(ue_seen == ue0 && cz_seen - cz0 == 1, "R4 skip completes without violation",
            {ue_seen - ue0, cz_seen - cz0}, {32'd0, 32'd1});

      // R5: output 6 bytes from 0x101
      cz0 = cz_seen;
      for (int i = 0; i < 6; i++) out_q.push_back(byte_at(16'h0101 + 16'(i)));
      load(16'h0101, 16'd6, 2'd2, 1'b0, 4'd0);
      wait_idle();
      check(out_q.size() == 0, "R5 output bytes delivered", out_q.size(), 0);
      check(xfer_addr == 16'h0107, "R5 output final address", xfer_addr, 16'h0107);
      check(cz_seen - cz0 == 1, "R10 output completion pulse", cz_seen - cz0, 1);

      // R6 R11: skipped output with back-pressure and a second load while busy
      cz0 = cz_seen;
      dev_out_ready = 1'b0;
      out_skip_run  = 1'b1;
      for (int i = 0; i < 5; i++) out_q.push_back(8'h00);
      load(16'h0042, 16'd5, 2'd3, 1'b1, 4'd0);
      repeat (3) @(negedge clk);
      load(16'h0900, 16'd99, 2'd0, 1'b0, 4'd1);
      repeat (2) @(negedge clk);
      dev_out_ready = 1'b1;
      wait_idle();
      out_skip_run = 1'b0;
      check(out_q.size() == 0, "R6 zeros delivered", out_q.size(), 0);
      check(xfer_addr == 16'h0047 && xfer_count == 16'd0, "R11 load while busy ignored",
            {xfer_addr, xfer_count}, {16'h0047, 16'd0});
      check(cz_seen - cz0 == 1, "R11 single completion", cz_seen - cz0, 1);

      // R10: zero-count descriptor
      cz0 = cz_seen;
      load(16'h0020, 16'd0, 2'd2, 1'b0, 4'd0);
      wait_idle();
      check(cz_seen - cz0 == 1 && !busy, "R10 zero count completes", cz_seen - cz0, 1);

      check(wr_q.size() == 0 && out_q.size() == 0, "R2 R5 queues drained",
            wr_q.size() + out_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule